// File: doc/BRIEF.md
# Sign-Magnitude Sequential Multiplier

This block multiplies two 40-bit sign-magnitude operands by repeated conditional addition and right shifting. Bit 39 of each operand is its sign and bits 38:0 its magnitude. A single start strobe captures both operands. The block then spends one clock per magnitude bit, 39 in all, building the 78-bit magnitude product. The result is split across two 40-bit registers: an accumulator holding the upper half and a multiplier-quotient register holding the lower half.

The sign of the result is the exclusive OR of the operand signs. It sits in accumulator bit 39. The magnitude is right-aligned in accumulator bits 38:0 (upper 39 product bits) and MQ bits 38:0 (lower 39 product bits), and MQ bit 39 is zero. A product whose magnitude is zero always gets a positive sign. The block suits a controller that issues a multiply, waits for the done pulse, and reads both registers. The registers keep their values until the next start.

Top module: `sm_seq_mult`

## Requirements
- R1: After reset, busy and done are 0 and both result registers read 0.
- R2: A start seen while idle makes busy high from the next cycle for exactly 39 cycles.
- R3: done is high for exactly one cycle: the first cycle in which busy is low again after an operation.
- R4: When done is high, accumulator bits 38:0 concatenated with MQ bits 38:0 equal the 78-bit product of the two operand magnitudes (operand bits 38:0).
- R5: When done is high, accumulator bit 39 equals operand A bit 39 XOR operand B bit 39, whenever the product magnitude is nonzero.
- R6: When either operand magnitude is zero, accumulator bit 39 is 0 at done, including for operands with sign 1 and magnitude 0.
- R7: MQ bit 39 is 0 when done is high.
- R8: A start asserted while busy is ignored, and the operation in progress completes with its original operands and timing.
- R9: After done, both result registers hold their values unchanged until the next accepted start.
- R10: Operand inputs are sampled only in the cycle start is accepted, and later changes do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a multiply, honoured only when idle |
| opA | input | 40 | Multiplicand, sign-magnitude |
| opB | input | 40 | Multiplier, sign-magnitude |
| busy | output | 1 | High while the 39 step cycles run |
| done | output | 1 | One-cycle completion pulse |
| accOut | output | 40 | Accumulator: sign and upper product half |
| mqOut | output | 40 | MQ register: lower product half |

## Verification
A step counter off by one shows in two ways. The busy window at the ports is 38 or 40 cycles instead of 39, and the product comes out shifted by one bit, which operands with a set top or bottom magnitude bit reveal at the first done pulse. A wrong add decision or a lost carry appears in the magnitude halves of the same result, and all-ones operands exercise the widest carry. A sign register that is captured at the wrong time or not cleared on a zero magnitude shows up only in accumulator bit 39 at done, so negative-zero operands and a start issued mid-operation with different signs are applied specifically.

// File: rtl/sm_mult_pkg.sv
package sm_mult_pkg;
  typedef struct packed {
    logic load;  // capture operands, clear accumulator
    logic step;  // perform one add-and-shift step
    logic last;  // current step is the final one
  } mulCtl_t;
endpackage

// File: rtl/sm_mult_ctrl.sv
module sm_mult_ctrl
  import sm_mult_pkg::*;
#(
  parameter int STEPS = 39
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  output mulCtl_t ctl,
  output logic    busy,
  output logic    done
);
  localparam int CNT_W = $clog2(STEPS + 1);

  typedef enum logic {S_IDLE, S_RUN} mulState_e;

  mulState_e  state;
  logic [CNT_W-1:0] stepCnt;
  logic       lastStep;

  assign lastStep = (state == S_RUN) && (stepCnt == CNT_W'(STEPS - 1));

  always_comb begin
    ctl.load = start && (state == S_IDLE);
    ctl.step = (state == S_RUN);
    ctl.last = lastStep;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            state   <= S_RUN;
            stepCnt <= '0;
          end
        end
        S_RUN: begin
          if (lastStep) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else begin
            stepCnt <= stepCnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy = (state == S_RUN);

  // R2: an accepted start raises busy on the next cycle with a fresh count
  a_r2_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.load |=> (busy && stepCnt == '0));

  // R2: the final step ends the busy window
  a_r2_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.last |=> !busy);

  // R3: falling busy is accompanied by done
  a_r3_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R3: done lasts one cycle only
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: a start during busy does not restart the count
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ctl.last) |=> (busy && stepCnt == $past(stepCnt) + 1'b1));
endmodule

// File: rtl/sm_mult_dpath.sv
module sm_mult_dpath
  import sm_mult_pkg::*;
#(
  parameter int WORD_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mulCtl_t           ctl,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  output logic [WORD_W-1:0] accOut,
  output logic [WORD_W-1:0] mqOut
);
  localparam int MAG_W = WORD_W - 1;
  localparam int SGN   = WORD_W - 1;

  logic [WORD_W-1:0] acReg;
  logic [WORD_W-1:0] mqReg;
  logic [MAG_W-1:0]  mcandReg;
  logic              signReg;
  logic [WORD_W-1:0] sumVal;
  logic              loadSign;

  // The accumulator stays below 2^MAG_W between steps, so the sum fits WORD_W bits.
  always_comb begin
    sumVal = acReg + (mqReg[0] ? {1'b0, mcandReg} : '0);
  end

  // Result sign: XOR of operand signs, forced positive for a zero magnitude.
  assign loadSign = (opA[SGN] ^ opB[SGN]) & (|opA[MAG_W-1:0]) & (|opB[MAG_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acReg    <= '0;
      mqReg    <= '0;
      mcandReg <= '0;
      signReg  <= 1'b0;
    end else if (ctl.load) begin
      acReg    <= '0;
      mqReg    <= {1'b0, opB[MAG_W-1:0]};
      mcandReg <= opA[MAG_W-1:0];
      signReg  <= loadSign;
    end else if (ctl.step) begin
      // Shift the (sum, MQ magnitude) pair right; MQ top bit stays out of the chain.
      acReg <= {(ctl.last ? signReg : 1'b0), sumVal[WORD_W-1:1]};
      mqReg <= {1'b0, sumVal[0], mqReg[MAG_W-1:1]};
    end
  end

  assign accOut = acReg;
  assign mqOut  = mqReg;

  // R9: results are held while no load or step is in progress
  a_r9_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.load && !ctl.step) |=> ($stable(acReg) && $stable(mqReg)));

  // R7: the MQ top bit is clear once the product is complete
  a_r7_mq_top_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.last |=> (mqReg[SGN] == 1'b0));

  // R6: no negative zero at completion
  a_r6_no_neg_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.last |=> !(acReg[SGN] && acReg[MAG_W-1:0] == '0 && mqReg[MAG_W-1:0] == '0));

  // R4: the accumulator does not carry into its top bit during the run
  a_r4_acc_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.step && !ctl.last) |=> (acReg[SGN] == 1'b0));
endmodule

// File: rtl/sm_seq_mult.sv
module sm_seq_mult
  import sm_mult_pkg::*;
#(
  parameter int WORD_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] accOut,
  output logic [WORD_W-1:0] mqOut
);
  localparam int STEPS = WORD_W - 1;

  mulCtl_t ctl;

  sm_mult_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .ctl   (ctl),
    .busy  (busy),
    .done  (done)
  );

  sm_mult_dpath #(.WORD_W(WORD_W)) u_dpath (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl    (ctl),
    .opA    (opA),
    .opB    (opB),
    .accOut (accOut),
    .mqOut  (mqOut)
  );
endmodule

// File: tb/test_sm_seq_mult.sv
`timescale 1ns/1ps
module test_sm_seq_mult;
  localparam int W = 40;
  localparam int M = W - 1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [W-1:0] opA, opB;
  logic         busy, done;
  logic [W-1:0] accOut, mqOut;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  sm_seq_mult i_sm_seq_mult (
    .clk(clk), .rst_n(rst_n), .start(start), .opA(opA), .opB(opB),
    .busy(busy), .done(done), .accOut(accOut), .mqOut(mqOut)
  );

  task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Expected 80-bit {AC, MQ} from the requirements.
  function automatic logic [79:0] expect_res(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [2*M-1:0] mag;
    logic           sgn;
    mag = {{M{1'b0}}, a[M-1:0]} * {{M{1'b0}}, b[M-1:0]};
    sgn = (a[M] ^ b[M]) && (mag != '0);
    return {sgn, mag[2*M-1:M], 1'b0, mag[M-1:0]};
  endfunction

  // Waits through a busy window starting at the current negedge; returns cycles counted.
  task automatic wait_busy(output int cyc);
    cyc = 0;
    while (busy && cyc < 100) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  // Accepts an operation, scrambles the inputs while busy (R10), checks R2..R7 and R9.
  task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    int cyc;
    logic [79:0] exp;
    exp = expect_res(a, b);
    @(negedge clk);
    opA = a; opB = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    opA = ~a; opB = {b[0], b[W-1:1]};
    wait_busy(cyc);
    chk(cyc == 39, {"R2 busy length ", tag}, 80'(cyc), 80'd39);
    chk(done == 1'b1, {"R3 done at end ", tag}, 80'(done), 80'd1);
    chk({accOut[M-1:0], mqOut[M-1:0]} == {exp[78:40], exp[38:0]},
        {"R4 R10 magnitude ", tag}, {accOut, mqOut}, exp);
    chk(accOut[M] == exp[79], {"R5 R6 sign ", tag}, 80'(accOut[M]), 80'(exp[79]));
    chk(mqOut[M] == 1'b0, {"R7 mq top ", tag}, 80'(mqOut[M]), 80'd0);
    @(negedge clk);
    chk(done == 1'b0, {"R3 done single ", tag}, 80'(done), 80'd0);
    repeat (3) @(negedge clk);
    chk({accOut, mqOut} == exp, {"R9 hold ", tag}, {accOut, mqOut}, exp);
  endtask

  task automatic test_reset();
    rst_n = 1'b0; start = 1'b0; opA = '0; opB = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R1 flags", {78'd0, busy, done}, 80'd0);
    chk({accOut, mqOut} == '0, "R1 registers", {accOut, mqOut}, 80'd0);
  endtask

  task automatic test_start_while_busy();
    int cyc;
    logic [W-1:0] a, b;
    logic [79:0] exp;
    a = 40'h80_0000_1234; b = 40'h00_0000_5678;
    exp = expect_res(a, b);
    @(negedge clk);
    opA = a; opB = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    opA = 40'h7F_FFFF_FFFF; opB = 40'hFF_FFFF_FFFF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_busy(cyc);
    chk(cyc == 28, "R8 timing kept", 80'(cyc), 80'd28);
    chk(done && {accOut, mqOut} == exp, "R8 result kept", {accOut, mqOut}, exp);
    @(negedge clk);
  endtask

  task automatic test_directed();
    run_mul(40'h00_0000_0003, 40'h00_0000_0005, "small");
    run_mul(40'h7F_FFFF_FFFF, 40'h7F_FFFF_FFFF, "max");
    run_mul(40'hFF_FFFF_FFFF, 40'h7F_FFFF_FFFF, "neg max");
    run_mul(40'h80_0000_0007, 40'h80_0000_0009, "neg neg");
    run_mul(40'h40_0000_0000, 40'h00_0000_0001, "top bit");
    run_mul(40'h00_0000_0001, 40'h40_0000_0000, "top mult");
    run_mul(40'h80_0000_0000, 40'h00_0000_0042, "R6 negzero a");
    run_mul(40'h00_1234_5678, 40'h80_0000_0000, "R6 negzero b");
    run_mul(40'h80_0000_0000, 40'h80_0000_0000, "R6 both zero");
  endtask

  task automatic test_random();
    for (int i = 0; i < 12; i++) begin
      logic [W-1:0] a, b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      run_mul(a, b, "random");
    end
  endtask

  initial begin
    #1_000_000;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    test_reset();
    test_directed();
    test_start_while_busy();
    test_random();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule